// File: doc/BRIEF.md
# Interrupt Pending and Sensitivity Controller

This block collects eight active-low external interrupt pins and eight active-high internal level requests into a single 32-bit pending word. A per-pin sensitivity setting decides how each pin is captured. In level mode the pending bit tracks the synchronized pin. In edge mode a falling edge sets a sticky bit, and software clears it by writing a one. A mask word selects which pending bits may reach the core. A read-only vector word reports the highest-priority active source. A registered interrupt line tells the core that at least one unmasked source is pending.

Software reaches the four words through a simple register bus. A write is a single-cycle strobe with a 2-bit address. The read data is a combinational function of the address. Bit positions are counted big-endian, so position 0 is word bit 31. In the upper half of the word, pin sources sit on even positions and internal sources on odd positions, and that order is also the priority order.

Top module: `irq_pend_ctrl`

## Requirements
- R1: Pin n owns big-endian position 2n (word bit 31-2n) and internal source n owns position 2n+1 (word bit 30-2n) in the pending, mask and sensitivity words.
- R2: Word bits 15:0 of the pending, mask and sensitivity words always read zero, and writes to them are ignored. Writes to word bits at internal positions of the sensitivity word are also ignored.
- R3: After reset, the pending, mask and sensitivity words read zero, `irq_o` is low and the vector word reads 0x3F000000.
- R4: An internal pending bit equals `lvl_req_i[n]` in the same cycle, and writes to the pending word never change it.
- R5: With sensitivity bit 0 (level mode), a pin's pending bit equals the inverted pin after a two-flop synchronizer: it changes on the second rising clock edge after the pin changes, and writes do not affect it.
- R6: With sensitivity bit 1 (edge mode), a falling edge of the synchronized pin sets the pending bit. The bit stays set after the pin returns high. Writing 1 at its position clears it, and writing 0 leaves it set.
- R7: If a falling edge and a write-one-to-clear of the same bit fall in the same cycle, the bit stays set.
- R8: Register addresses are: 0 pending, 1 mask, 2 sensitivity, 3 vector. The vector word is read-only, and writes to address 3 have no effect.
- R9: A pending bit drives the interrupt output only while the mask bit at the same position is 1.
- R10: `irq_o` is registered: it is high in the cycle after some pending bit is set together with its mask bit, and low in the cycle after none is.
- R11: The vector word carries in bits 31:24 the lowest big-endian position that is both pending and unmasked, and in bit 23 a valid flag. All other bits are zero. With no such position it reads index 0x3F with valid 0.
- R12: In edge mode a rising edge, or a pin held low, does not set the pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_pin_n_i | input | 8 | External interrupt pins, active-low, asynchronous |
| lvl_req_i | input | 8 | Internal level requests, active-high, synchronous |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 2 | Register select |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for the selected register |
| irq_o | output | 1 | Combined interrupt request to the core |

## Verification
The bench sends a clear write exactly in the cycle in which a falling edge is detected. A design that let the clear win would lose that interrupt. It holds a pin low after clearing its edge-mode bit, and it raises a pin, to catch a detector that responds to a level or to the wrong edge. It also writes ones over level-mode and internal bits, and over the reserved and vector words, which exposes a pending word that stores writes where it should ignore them. The bench checks the synchronizer latency and the one-cycle lag of the output cycle by cycle, and it reads the vector while several sources compete, which exposes an encoder that picks the wrong end of the word.

// File: rtl/irq_pend_pkg.sv
package irq_pend_pkg;
  localparam int REG_W   = 32;
  localparam int PIN_CNT = 8;
  localparam int ADDR_W  = 2;
  localparam int IDX_W   = 6;
  localparam int SRC_CNT = 2 * PIN_CNT;

  typedef enum logic [ADDR_W-1:0] {
    SEL_PEND = 2'd0,
    SEL_MASK = 2'd1,
    SEL_SENS = 2'd2,
    SEL_VEC  = 2'd3
  } reg_sel_e;

  localparam logic [IDX_W-1:0] IDX_NONE = '1;

  // word bit of pin n (big-endian position 2n)
  function automatic int pin_pos(input int n);
    return REG_W - 1 - 2 * n;
  endfunction

  // word bit of internal source n (big-endian position 2n+1)
  function automatic int lvl_pos(input int n);
    return REG_W - 2 - 2 * n;
  endfunction

  function automatic logic [REG_W-1:0] src_field();
    logic [REG_W-1:0] m;
    m = '0;
    for (int i = 0; i < SRC_CNT; i++) m[REG_W-1-i] = 1'b1;
    return m;
  endfunction

  function automatic logic [REG_W-1:0] pin_field();
    logic [REG_W-1:0] m;
    m = '0;
    for (int i = 0; i < PIN_CNT; i++) m[pin_pos(i)] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_sync_n = out_q;
endmodule

// File: rtl/irq_pin_chan.sv
module irq_pin_chan (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n_i,
  input  logic edge_mode_i,
  input  logic clr_i,
  output logic pend_o
);
  logic meta_q, sync_q, prev_q;
  logic latch_q, latch_d;
  logic asserted, fall;

  // synchronizer and history idle high (pin inactive)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b1;
      sync_q <= 1'b1;
      prev_q <= 1'b1;
    end else begin
      meta_q <= pin_n_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  always_comb begin
    asserted = ~sync_q;
    fall     = prev_q & ~sync_q;
    // a new edge takes precedence over a same-cycle clear
    if (edge_mode_i) latch_d = fall | (latch_q & ~clr_i);
    else             latch_d = 1'b0;
    pend_o   = edge_mode_i ? latch_q : asserted;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) latch_q <= 1'b0;
    else        latch_q <= latch_d;
  end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int REG_W   = irq_pend_pkg::REG_W,
  parameter int SRC_CNT = irq_pend_pkg::SRC_CNT,
  parameter int IDX_W   = irq_pend_pkg::IDX_W
) (
  input  logic [REG_W-1:0] active_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             valid_o
);
  always_comb begin
    idx_o   = '1;
    valid_o = 1'b0;
    // scan from the lowest priority up so the last hit is the winner
    for (int k = SRC_CNT - 1; k >= 0; k--) begin
      if (active_i[REG_W-1-k]) begin
        idx_o   = IDX_W'(k);
        valid_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_pend_ctrl.sv
module irq_pend_ctrl
  import irq_pend_pkg::*;
#(
  parameter int PINS = irq_pend_pkg::PIN_CNT
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [PINS-1:0]      irq_pin_n_i,
  input  logic [PINS-1:0]      lvl_req_i,
  input  logic                 bus_we_i,
  input  logic [ADDR_W-1:0]    bus_addr_i,
  input  logic [REG_W-1:0]     bus_wdata_i,
  output logic [REG_W-1:0]     bus_rdata_o,
  output logic                 irq_o
);
  localparam logic [REG_W-1:0] SRC_FIELD = src_field();
  localparam logic [REG_W-1:0] PIN_FIELD = pin_field();
  localparam int               VEC_PAD   = REG_W - 9;

  logic             rst_int_n;
  logic [PINS-1:0]  pin_pend;
  logic [REG_W-1:0] pend_w;
  logic [REG_W-1:0] mask_q, mask_d;
  logic [REG_W-1:0] sens_q, sens_d;
  logic             mask_en, sens_en, clr_hit;
  logic             irq_q, irq_d;
  logic [IDX_W-1:0] vec_idx;
  logic             vec_valid;

  irq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  assign clr_hit = bus_we_i && (bus_addr_i == SEL_PEND);

  for (genvar g = 0; g < PINS; g++) begin : g_pin
    localparam int PB = pin_pos(g);
    irq_pin_chan u_chan (
      .clk         (clk),
      .rst_n       (rst_int_n),
      .pin_n_i     (irq_pin_n_i[g]),
      .edge_mode_i (sens_q[PB]),
      .clr_i       (clr_hit && bus_wdata_i[PB]),
      .pend_o      (pin_pend[g])
    );
  end

  always_comb begin
    pend_w = '0;
    for (int n = 0; n < PINS; n++) begin
      pend_w[pin_pos(n)] = pin_pend[n];
      pend_w[lvl_pos(n)] = lvl_req_i[n];
    end
  end

  // next state for the software registers
  always_comb begin
    mask_en = bus_we_i && (bus_addr_i == SEL_MASK);
    sens_en = bus_we_i && (bus_addr_i == SEL_SENS);
    mask_d  = bus_wdata_i & SRC_FIELD;
    sens_d  = bus_wdata_i & PIN_FIELD;
    irq_d   = |(pend_w & mask_q);
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      mask_q <= '0;
    end else if (mask_en) begin
      mask_q <= mask_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      sens_q <= '0;
    end else if (sens_en) begin
      sens_q <= sens_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) irq_q <= 1'b0;
    else            irq_q <= irq_d;
  end

  irq_prio_enc #(
    .REG_W   (REG_W),
    .SRC_CNT (2 * PINS),
    .IDX_W   (IDX_W)
  ) u_enc (
    .active_i (pend_w & mask_q),
    .idx_o    (vec_idx),
    .valid_o  (vec_valid)
  );

  always_comb begin
    unique case (bus_addr_i)
      SEL_PEND: bus_rdata_o = pend_w;
      SEL_MASK: bus_rdata_o = mask_q;
      SEL_SENS: bus_rdata_o = sens_q;
      default:  bus_rdata_o = {{(8 - IDX_W){1'b0}}, vec_idx, vec_valid, {VEC_PAD{1'b0}}};
    endcase
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/irq_pend_chk.sv
module irq_pend_chk
  import irq_pend_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [PIN_CNT-1:0] lvl_req_i,
  input logic              bus_we_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [REG_W-1:0]  bus_wdata_i,
  input logic [REG_W-1:0]  bus_rdata_o,
  input logic [REG_W-1:0]  pend_w,
  input logic [REG_W-1:0]  mask_q,
  input logic [REG_W-1:0]  sens_q,
  input logic              irq_o
);
  AST_PEND_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr_i == SEL_PEND) |-> (bus_rdata_o[15:0] == 16'h0)); // R2

  AST_MASK_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    mask_q[15:0] == 16'h0); // R2

  AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (|(pend_w & mask_q)) |=> irq_o); // R10

  AST_IRQ_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(pend_w & mask_q)) |=> !irq_o); // R10

  AST_VEC_NONE: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_addr_i == SEL_VEC) && ((pend_w & mask_q) == '0))
      |-> (bus_rdata_o == 32'h3F00_0000)); // R11

  for (genvar g = 0; g < PIN_CNT; g++) begin : g_chk
    localparam int PB = pin_pos(g);
    localparam int LB = lvl_pos(g);

    AST_LVL_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr_i == SEL_PEND) |-> (bus_rdata_o[LB] == lvl_req_i[g])); // R4

    AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (sens_q[PB] && pend_w[PB] && !bus_we_i) |=> pend_w[PB]); // R6
  end
endmodule

bind irq_pend_ctrl irq_pend_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_int_n),
  .lvl_req_i   (lvl_req_i),
  .bus_we_i    (bus_we_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .bus_rdata_o (bus_rdata_o),
  .pend_w      (pend_w),
  .mask_q      (mask_q),
  .sens_q      (sens_q),
  .irq_o       (irq_o)
);

// File: tb/tb_irq_pend_ctrl.sv
module tb_irq_pend_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  pin_n;
  logic [7:0]  lvl;
  logic        we;
  logic [1:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        irq;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  irq_pend_ctrl dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .irq_pin_n_i (pin_n),
    .lvl_req_i   (lvl),
    .bus_we_i    (we),
    .bus_addr_i  (addr),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata),
    .irq_o       (irq)
  );

  function automatic int pb(input int n); return 31 - 2 * n; endfunction
  function automatic int lb(input int n); return 30 - 2 * n; endfunction
  function automatic logic [31:0] vec(input int idx, input bit v);
    return {2'b00, 6'(idx), v, 23'h0};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(2'd0, d); chk("R3 pending", d, 32'h0);
    rd(2'd1, d); chk("R3 mask", d, 32'h0);
    rd(2'd2, d); chk("R3 sens", d, 32'h0);
    rd(2'd3, d); chk("R3 vector", d, 32'h3F00_0000);
    chk("R3 irq", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_rsvd();
    logic [31:0] d;
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, d); chk("R2 mask reserved", d, 32'hFFFF_0000);
    wr(2'd2, 32'hFFFF_FFFF);
    rd(2'd2, d); chk("R2 sens reserved", d, 32'hAAAA_0000);
    wr(2'd2, 32'h0);
    wr(2'd1, 32'h0);
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, d); chk("R2 pending reserved", d, 32'h0);
    wr(2'd3, 32'hFFFF_FFFF);
    rd(2'd3, d); chk("R8 vector read-only", d, 32'h3F00_0000);
  endtask

  task automatic t_lvl_src();
    logic [31:0] d;
    for (int n = 0; n < 8; n++) begin
      @(negedge clk); lvl = 8'(1 << n);
      rd(2'd0, d); chk("R1 R4 internal position", d, 32'(1) << lb(n));
    end
    @(negedge clk); lvl = 8'hFF;
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, d); chk("R4 write ignored", d, 32'h5555_0000);
    @(negedge clk); lvl = 8'h00;
    rd(2'd0, d); chk("R4 withdraw clears", d, 32'h0);
  endtask

  task automatic t_level_pin();
    logic [31:0] d;
    @(negedge clk); pin_n[3] = 1'b0;
    rd(2'd0, d); chk("R5 one edge not enough", d, 32'h0);
    rd(2'd0, d); chk("R5 R1 pin position", d, 32'(1) << pb(3));
    wr(2'd0, 32'(1) << pb(3));
    rd(2'd0, d); chk("R5 write ignored", d, 32'(1) << pb(3));
    @(negedge clk); pin_n[3] = 1'b1;
    idle(3);
    rd(2'd0, d); chk("R5 release clears", d, 32'h0);
  endtask

  task automatic t_edge_pin();
    logic [31:0] d;
    wr(2'd2, 32'(1) << pb(5));
    @(negedge clk); pin_n[5] = 1'b0;
    idle(4);
    rd(2'd0, d); chk("R6 edge sets", d, 32'(1) << pb(5));
    @(negedge clk); pin_n[5] = 1'b1;
    idle(4);
    rd(2'd0, d); chk("R6 sticky after release", d, 32'(1) << pb(5));
    wr(2'd0, 32'h0);
    rd(2'd0, d); chk("R6 write zero keeps", d, 32'(1) << pb(5));
    wr(2'd0, 32'(1) << pb(5));
    rd(2'd0, d); chk("R6 write one clears", d, 32'h0);
    @(negedge clk); pin_n[5] = 1'b0;
    idle(4);
    wr(2'd0, 32'(1) << pb(5));
    idle(3);
    rd(2'd0, d); chk("R12 held low no reassert", d, 32'h0);
    @(negedge clk); pin_n[5] = 1'b1;
    idle(4);
    rd(2'd0, d); chk("R12 rising edge ignored", d, 32'h0);
    wr(2'd2, 32'h0);
  endtask

  task automatic t_race();
    logic [31:0] d;
    wr(2'd2, 32'(1) << pb(1));
    @(negedge clk); pin_n[1] = 1'b0;
    idle(4);
    @(negedge clk); pin_n[1] = 1'b1;
    idle(4);
    @(negedge clk); pin_n[1] = 1'b0;
    @(posedge clk);
    @(posedge clk);
    wr(2'd0, 32'(1) << pb(1));
    rd(2'd0, d); chk("R7 edge beats clear", d, 32'(1) << pb(1));
    wr(2'd0, 32'(1) << pb(1));
    rd(2'd0, d); chk("R7 later clear works", d, 32'h0);
    @(negedge clk); pin_n[1] = 1'b1;
    wr(2'd2, 32'h0);
    idle(3);
  endtask

  task automatic t_mask();
    @(negedge clk); lvl[2] = 1'b1;
    idle(3);
    chk("R9 masked off", {31'h0, irq}, 32'h0);
    wr(2'd1, 32'(1) << pb(2));
    idle(2);
    chk("R9 other mask bit", {31'h0, irq}, 32'h0);
    wr(2'd1, 32'(1) << lb(2));
    idle(1);
    chk("R9 unmasked", {31'h0, irq}, 32'h1);
    @(negedge clk); lvl[2] = 1'b0;
    #1 chk("R10 still high same cycle", {31'h0, irq}, 32'h1);
    @(negedge clk);
    chk("R10 falls one cycle later", {31'h0, irq}, 32'h0);
    @(negedge clk); lvl[2] = 1'b1;
    #1 chk("R10 low same cycle", {31'h0, irq}, 32'h0);
    @(negedge clk);
    chk("R10 rises one cycle later", {31'h0, irq}, 32'h1);
    @(negedge clk); lvl[2] = 1'b0;
    wr(2'd1, 32'h0);
  endtask

  task automatic t_vector();
    logic [31:0] d;
    wr(2'd1, 32'hFFFF_0000);
    @(negedge clk); lvl = 8'b0010_1000;
    rd(2'd3, d); chk("R11 lowest of two", d, vec(7, 1'b1));
    @(negedge clk); pin_n[2] = 1'b0;
    idle(3);
    rd(2'd3, d); chk("R11 pin takes priority", d, vec(4, 1'b1));
    wr(2'd1, 32'hFFFF_0000 & ~(32'(1) << pb(2)) & ~(32'(1) << lb(3)));
    rd(2'd3, d); chk("R11 masked winners skipped", d, vec(11, 1'b1));
    @(negedge clk); lvl = 8'h00; pin_n[2] = 1'b1;
    idle(3);
    rd(2'd3, d); chk("R11 none active", d, vec(63, 1'b0));
    wr(2'd1, 32'h0);
  endtask

  initial begin
    rst_n = 1'b0; pin_n = 8'hFF; lvl = 8'h00;
    we = 1'b0; addr = 2'd0; wdata = '0;
    idle(3);
    rst_n = 1'b1;
    idle(3);
    t_reset();
    t_rsvd();
    t_lvl_src();
    t_level_pin();
    t_edge_pin();
    t_race();
    t_mask();
    t_vector();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule